// File: doc/BRIEF.md
# RS-485 Driver-Enable UART Transmitter

This block is a UART transmitter for a half-duplex RS-485 link. It sends each byte as one frame: a start bit (0), eight data bits with the least significant bit first, and one stop bit (1). The serial line idles high. The block also drives the transceiver's driver-enable line around each frame. When a byte is accepted, driver-enable goes active. The block then waits a programmable lead time, sends the frame, waits a programmable trail time after the stop bit, and releases driver-enable. Both guard times are counted in sample ticks. A 16-bit divisor of the system clock sets the tick rate. An oversampling-mode bit sets whether a bit lasts 16 or 8 ticks.

The transmitter takes a byte over a valid/ready handshake. It accepts bytes only while both the unit enable and the transmit enable are set. The divisor, the oversampling mode and both guard times are captured only while the unit is disabled, so they stay frozen for as long as the unit is enabled. A byte offered during the trail wait is sent straight away with driver-enable still held, so a burst of bytes keeps the bus driven. A one-cycle completion pulse marks the release of driver-enable.

Top module: `rs485_uart_tx`

## Requirements
- R1: Out of reset, `txd` is 1, and `drv_en`, `busy`, `tx_done` and `in_ready` are all 0.
- R2: `in_ready` is 1 only while `unit_en` and `tx_en` are both 1 and no frame is being started or sent. While `tx_en` is 0, an offered byte is not taken and `drv_en` stays low.
- R3: A frame is a 0 start bit, then `in_data[0]` through `in_data[7]`, then a 1 stop bit. Each bit lasts B*D clock cycles, where D = max(`baud_div`, 1).
- R4: B is 16 when `ovs8` is 0 and 8 when `ovs8` is 1. One sample tick is D clock cycles.
- R5: The start bit begins (L+1)*D cycles after `drv_en` rises, where L is the 5-bit lead setting. With L = 0, the start bit begins on the first tick after `drv_en` rises.
- R6: `drv_en` falls (T+1)*D cycles after the stop bit ends, where T is the 5-bit trail setting.
- R7: `baud_div`, `ovs8`, `lead_cfg` and `trail_cfg` are captured only while `unit_en` is 0. Changes made while it is 1 have no effect on the frames sent.
- R8: A byte accepted during the trail wait keeps `drv_en` high. Its start bit begins on the next sample tick, with no lead wait.
- R9: `tx_done` is a one-cycle pulse in the cycle in which `drv_en` falls after a trail wait. `busy` is high from acceptance until that cycle.
- R10: Clearing `unit_en` returns the block to idle on the next cycle, with `txd` 1, `drv_en` 0, `busy` 0 and no `tx_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_en | input | 1 | Unit enable; when 0, aborts any frame and opens the configuration capture |
| tx_en | input | 1 | Transmit enable; gates acceptance of bytes |
| ovs8 | input | 1 | Oversampling mode: 0 gives 16 ticks per bit, 1 gives 8 ticks per bit |
| baud_div | input | 16 | Clock cycles per sample tick (0 is treated as 1) |
| lead_cfg | input | 5 | Ticks between `drv_en` rising and the start bit |
| trail_cfg | input | 5 | Ticks between the end of the stop bit and `drv_en` falling |
| in_valid | input | 1 | A byte is offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | The offered byte is taken at this clock edge |
| txd | output | 1 | Serial output line |
| drv_en | output | 1 | Transceiver driver enable |
| busy | output | 1 | A transfer is in progress |
| tx_done | output | 1 | One-cycle pulse when `drv_en` is released |

## Verification
The bench measures exact cycle distances. It times the span from `drv_en` rising to the start bit, and from the start bit to `drv_en` falling. An off-by-one in the guard countdown, or a tick divider that runs free instead of restarting at acceptance, shows up as a lead or trail span that is one tick long or short. The bench changes every configuration input while the unit is enabled. A missing capture lock would then send frames at the wrong rate or with the wrong guard times, and the decode would fail. A burst of two bytes checks three things: `drv_en` must not drop between the bytes, only one completion pulse may appear, and the second start bit must follow the first frame's stop bit by exactly one tick. The bench also aborts a frame during a long lead wait. A design that ignores the abort would keep `drv_en` high or would emit a stray completion pulse.

// File: rtl/rs485_tx_pkg.sv
// Shared types for the RS-485 driver-enable UART transmitter.
package rs485_tx_pkg;
    // Transmit sequencer phases: idle, lead guard, frame shifting, trail guard.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SEND  = 2'd2,
        ST_TRAIL = 2'd3
    } tx_state_e;
endpackage

// File: rtl/rs485_cfg_lock.sv
// Configuration shadow registers.
// Captures divisor, oversampling mode and both guard times on every cycle in
// which the unit is disabled. While the unit is enabled, it holds the captured
// values. Assumes that the inputs are set up before unit_en rises.
module rs485_cfg_lock #(
    parameter int DIV_W   = 16,
    parameter int GUARD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unit_en,
    input  logic [DIV_W-1:0]   div_in,
    input  logic               ovs_in,
    input  logic [GUARD_W-1:0] lead_in,
    input  logic [GUARD_W-1:0] trail_in,
    output logic [DIV_W-1:0]   div_q,
    output logic               ovs_q,
    output logic [GUARD_W-1:0] lead_q,
    output logic [GUARD_W-1:0] trail_q
);
    // Load the shadow copy only while disabled; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            ovs_q   <= 1'b0;
            lead_q  <= '0;
            trail_q <= '0;
        end else if (!unit_en) begin
            div_q   <= div_in;
            ovs_q   <= ovs_in;
            lead_q  <= lead_in;
            trail_q <= trail_in;
        end
    end
endmodule

// File: rtl/rs485_tick_gen.sv
// Sample-tick divider.
// Raises tick for one cycle every max(div,1) clock cycles while enabled.
// A restart pulse puts the phase back to zero, so the first tick comes
// exactly div cycles later. Assumes that div is stable while enabled.
module rs485_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_m1;

    // Terminal count; a divisor of zero behaves like one.
    always_comb div_m1 = (div == '0) ? '0 : div - 1'b1;

    // Tick fires at the terminal count while enabled.
    always_comb tick = en && (cnt == div_m1);

    // Phase counter: cleared on disable, on restart and on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (!en || restart || tick) cnt <= '0;
        else                             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rs485_tx_fsm.sv
// Transmit sequencer.
// Accepts a byte when the unit and transmitter are enabled and the sequencer
// is idle or in its trail wait. It holds driver-enable through the lead wait,
// the shifted frame (start, data LSB first, stop) and the trail wait. It
// pulses done when driver-enable drops. All timing advances on tick.
// Assumes that ovs8, lead and trail are stable while unit_en is 1.
module rs485_tx_fsm
    import rs485_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int GUARD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unit_en,
    input  logic               tx_en,
    input  logic               tick,
    input  logic               ovs8,
    input  logic [GUARD_W-1:0] lead,
    input  logic [GUARD_W-1:0] trail,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    output logic               in_ready,
    output logic               restart,
    output logic               txd,
    output logic               drv_en,
    output logic               busy,
    output logic               tx_done
);
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int BIT_CNT_W  = $clog2(FRAME_BITS);
    localparam int SUB_W      = 4;
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_BITS - 1);
    localparam logic [SUB_W-1:0]     LAST_16  = SUB_W'(15);
    localparam logic [SUB_W-1:0]     LAST_8   = SUB_W'(7);

    tx_state_e               state;
    logic [GUARD_W-1:0]      guard_cnt;
    logic [SUB_W-1:0]        sub_cnt;
    logic [BIT_CNT_W-1:0]    bit_cnt;
    logic [FRAME_BITS-1:0]   shreg;
    logic                    done_q;
    logic                    accept;
    logic                    last_sub;

    // Handshake: ready when enabled and not inside a lead wait or a frame.
    always_comb begin
        in_ready = unit_en && tx_en && (state == ST_IDLE || state == ST_TRAIL);
        accept   = in_valid && in_ready;
        restart  = accept && (state == ST_IDLE);
    end

    // End of the current bit: 16 or 8 ticks by oversampling mode.
    always_comb last_sub = ovs8 ? (sub_cnt == LAST_8) : (sub_cnt == LAST_16);

    // Line and status outputs decoded from the sequencer state.
    always_comb begin
        txd     = (state == ST_SEND) ? shreg[0] : 1'b1;
        drv_en  = (state != ST_IDLE);
        busy    = (state != ST_IDLE);
        tx_done = done_q;
    end

    // Sequencer: guard countdowns, bit timing and frame shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            guard_cnt <= '0;
            sub_cnt   <= '0;
            bit_cnt   <= '0;
            shreg     <= '1;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!unit_en) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (accept) begin
                            state     <= ST_LEAD;
                            guard_cnt <= lead;
                            shreg     <= {1'b1, in_data, 1'b0};
                        end
                    end
                    ST_LEAD: begin
                        if (tick) begin
                            if (guard_cnt == '0) begin
                                state   <= ST_SEND;
                                sub_cnt <= '0;
                                bit_cnt <= '0;
                            end else begin
                                guard_cnt <= guard_cnt - 1'b1;
                            end
                        end
                    end
                    ST_SEND: begin
                        if (tick) begin
                            if (last_sub) begin
                                sub_cnt <= '0;
                                shreg   <= {1'b1, shreg[FRAME_BITS-1:1]};
                                if (bit_cnt == LAST_BIT) begin
                                    state     <= ST_TRAIL;
                                    guard_cnt <= trail;
                                end else begin
                                    bit_cnt <= bit_cnt + 1'b1;
                                end
                            end else begin
                                sub_cnt <= sub_cnt + 1'b1;
                            end
                        end
                    end
                    ST_TRAIL: begin
                        if (accept) begin
                            state     <= ST_LEAD;
                            guard_cnt <= '0;
                            shreg     <= {1'b1, in_data, 1'b0};
                        end else if (tick) begin
                            if (guard_cnt == '0) begin
                                state  <= ST_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                guard_cnt <= guard_cnt - 1'b1;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rs485_uart_tx.sv
// RS-485 driver-enable UART transmitter, top level.
// Connects the configuration lock, the sample-tick divider and the transmit
// sequencer. Assumes a single clock and a synchronous active-low reset.
module rs485_uart_tx #(
    parameter int DIV_W   = 16,
    parameter int GUARD_W = 5,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unit_en,
    input  logic               tx_en,
    input  logic               ovs8,
    input  logic [DIV_W-1:0]   baud_div,
    input  logic [GUARD_W-1:0] lead_cfg,
    input  logic [GUARD_W-1:0] trail_cfg,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    output logic               in_ready,
    output logic               txd,
    output logic               drv_en,
    output logic               busy,
    output logic               tx_done
);
    logic [DIV_W-1:0]   div_q;
    logic               ovs_q;
    logic [GUARD_W-1:0] lead_q;
    logic [GUARD_W-1:0] trail_q;
    logic               tick;
    logic               restart;

    rs485_cfg_lock #(.DIV_W(DIV_W), .GUARD_W(GUARD_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .unit_en(unit_en),
        .div_in(baud_div), .ovs_in(ovs8), .lead_in(lead_cfg), .trail_in(trail_cfg),
        .div_q(div_q), .ovs_q(ovs_q), .lead_q(lead_q), .trail_q(trail_q)
    );

    rs485_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(unit_en), .restart(restart),
        .div(div_q), .tick(tick)
    );

    rs485_tx_fsm #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .tx_en(tx_en),
        .tick(tick), .ovs8(ovs_q), .lead(lead_q), .trail(trail_q),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .restart(restart), .txd(txd), .drv_en(drv_en), .busy(busy),
        .tx_done(tx_done)
    );
endmodule

// File: rtl/rs485_tx_checker.sv
// Property checker for rs485_uart_tx, bound to every instance of the top.
// It observes the ports and the locked guard-time registers.
module rs485_tx_checker #(
    parameter int GUARD_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               unit_en,
    input logic               tx_en,
    input logic               in_ready,
    input logic               txd,
    input logic               drv_en,
    input logic               busy,
    input logic               tx_done,
    input logic [GUARD_W-1:0] lead_q,
    input logic [GUARD_W-1:0] trail_q
);
    // R1: a reset cycle leaves the line idle and the driver off.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (txd && !drv_en && !busy && !tx_done));

    // R2: readiness requires both enables.
    p_ready_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (unit_en && tx_en));

    // R3: the line is driven low only while the driver is enabled.
    p_line_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> txd);

    // R7: guard times hold while the unit stays enabled.
    p_guard_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_en && $past(unit_en)) |-> ($stable(lead_q) && $stable(trail_q)));

    // R9: completion is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    // R9: completion coincides with driver-enable falling.
    p_done_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $fell(drv_en));

    // R9: busy tracks the whole driven interval.
    p_busy_de_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy == drv_en);

    // R6: a release while still enabled always comes with completion.
    p_fall_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drv_en) && $past(unit_en)) |-> tx_done);

    // R10: disabling the unit releases the bus on the next cycle.
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |=> (!drv_en && txd && !tx_done));
endmodule

bind rs485_uart_tx rs485_tx_checker #(.GUARD_W(GUARD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .tx_en(tx_en),
    .in_ready(in_ready), .txd(txd), .drv_en(drv_en), .busy(busy),
    .tx_done(tx_done), .lead_q(lead_q), .trail_q(trail_q)
);

// File: tb/test_rs485_uart_tx.sv
// Scoreboard bench for rs485_uart_tx: the send task queues expected frames;
// the monitor decodes the line and compares timing and data.
module test_rs485_uart_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unit_en = 1'b0;
    logic        tx_en = 1'b0;
    logic        ovs8 = 1'b0;
    logic [15:0] baud_div = 16'd0;
    logic [4:0]  lead_cfg = 5'd0;
    logic [4:0]  trail_cfg = 5'd0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        in_ready, txd, drv_en, busy, tx_done;

    rs485_uart_tx i_rs485_uart_tx (
        .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .tx_en(tx_en),
        .ovs8(ovs8), .baud_div(baud_div), .lead_cfg(lead_cfg),
        .trail_cfg(trail_cfg), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .txd(txd), .drv_en(drv_en), .busy(busy),
        .tx_done(tx_done)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [7:0] data;
        int         lead;   // cycles DE rise -> start, -1 skips
        int         gap;    // cycles previous start -> start, -1 skips
        int         tail;   // cycles start -> DE fall, -1 skips
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    int   cyc      = 0;
    int   cur_d    = 1;
    int   cur_b    = 16;
    int   rise_stamp = 0;
    int   n_falls  = 0;
    int   n_done   = 0;
    int   last_start = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Edge tracker for driver-enable and completion pulses.
    initial begin
        logic prev_de = 1'b0;
        forever begin
            @(negedge clk);
            if (drv_en && !prev_de) rise_stamp = cyc;
            if (!drv_en && prev_de) n_falls++;
            if (tx_done) n_done++;
            prev_de = drv_en;
        end
    end

    // Monitor: decode each frame at mid-bit and compare with the queue.
    initial begin
        logic prev_tx = 1'b1;
        forever begin
            @(negedge clk);
            if (prev_tx && !txd) begin
                int   st;
                int   bd;
                logic [7:0] got;
                logic sb, pb;
                exp_t e;
                st = cyc;
                bd = cur_b * cur_d;
                repeat (bd / 2) @(negedge clk);
                sb = txd;
                for (int i = 0; i < 8; i++) begin
                    repeat (bd) @(negedge clk);
                    got[i] = txd;
                end
                repeat (bd) @(negedge clk);
                pb = txd;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected frame", int'(got), -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(sb == 1'b0, "R3 start bit", int'(sb), 0);
                    chk(pb == 1'b1, "R3 stop bit", int'(pb), 1);
                    chk(got == e.data, "R3 R4 data byte", int'(got), int'(e.data));
                    if (e.lead >= 0)
                        chk(st - rise_stamp == e.lead, "R5 lead span", st - rise_stamp, e.lead);
                    if (e.gap >= 0)
                        chk(st - last_start == e.gap, "R8 start gap", st - last_start, e.gap);
                    last_start = st;
                    if (e.tail >= 0) begin
                        while (drv_en) @(negedge clk);
                        chk(cyc - st == e.tail, "R6 trail span", cyc - st, e.tail);
                        chk(tx_done == 1'b1, "R9 done at DE fall", int'(tx_done), 1);
                    end
                end
                prev_tx = 1'b1;
            end else begin
                prev_tx = txd;
            end
        end
    end

    // Load configuration with the unit disabled, then enable it.
    task automatic configure(input int d, input bit o, input int l, input int t);
        @(negedge clk);
        unit_en = 1'b0;
        baud_div = 16'(d); ovs8 = o; lead_cfg = 5'(l); trail_cfg = 5'(t);
        @(negedge clk);
        unit_en = 1'b1; tx_en = 1'b1;
        cur_d = (d == 0) ? 1 : d;
        cur_b = o ? 8 : 16;
    endtask

    // Offer one byte, optionally queueing its expectation; return after accept.
    task automatic send(input logic [7:0] d, input bit push, input exp_t e);
        @(negedge clk);
        if (push) exp_q.push_back(e);
        in_valid = 1'b1; in_data = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        exp_t e;
        int   falls0, done0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        chk(drv_en == 1'b0, "R1 drv_en low", int'(drv_en), 0);
        chk(busy == 1'b0, "R1 busy low", int'(busy), 0);
        chk(tx_done == 1'b0, "R1 tx_done low", int'(tx_done), 0);
        chk(in_ready == 1'b0, "R1 in_ready low", int'(in_ready), 0);
        rst_n = 1'b1;

        // R2: transmit enable off blocks acceptance.
        @(negedge clk);
        unit_en = 1'b1; tx_en = 1'b0; in_valid = 1'b1; in_data = 8'h99;
        repeat (20) @(negedge clk);
        chk(in_ready == 1'b0, "R2 ready with tx_en=0", int'(in_ready), 0);
        chk(drv_en == 1'b0, "R2 no DE with tx_en=0", int'(drv_en), 0);
        in_valid = 1'b0; unit_en = 1'b0;

        // R3 R5 R6: zero guard times, 16x, divisor 2.
        configure(2, 1'b0, 0, 0);
        e = '{data: 8'hA5, lead: 2, gap: -1, tail: 320 + 2};
        send(8'hA5, 1'b1, e);
        wait_idle();

        // R4 R5 R6: 8x, divisor 3, nonzero guards.
        configure(3, 1'b1, 5, 7);
        e = '{data: 8'h3C, lead: 18, gap: -1, tail: 240 + 24};
        send(8'h3C, 1'b1, e);
        wait_idle();

        // R5 R6: maximum guard times, divisor 0 acts as 1.
        configure(0, 1'b0, 31, 31);
        e = '{data: 8'h01, lead: 32, gap: -1, tail: 160 + 32};
        send(8'h01, 1'b1, e);
        wait_idle();

        // R7: inputs changed while enabled must not take effect.
        configure(3, 1'b1, 4, 1);
        @(negedge clk);
        baud_div = 16'd7; ovs8 = 1'b0; lead_cfg = 5'd0; trail_cfg = 5'd9;
        e = '{data: 8'h81, lead: 15, gap: -1, tail: 240 + 6};
        send(8'h81, 1'b1, e);
        wait_idle();

        // R8: second byte accepted during trail wait.
        configure(2, 1'b0, 3, 31);
        falls0 = n_falls; done0 = n_done;
        e = '{data: 8'h5A, lead: 8, gap: -1, tail: -1};
        send(8'h5A, 1'b1, e);
        e = '{data: 8'hC3, lead: -1, gap: 320 + 2, tail: 320 + 64};
        send(8'hC3, 1'b1, e);
        wait_idle();
        chk(n_falls - falls0 == 1, "R8 single DE release", n_falls - falls0, 1);
        chk(n_done - done0 == 1, "R9 single done pulse", n_done - done0, 1);
        chk(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);

        // R10: abort during a long lead wait.
        configure(2, 1'b0, 31, 0);
        done0 = n_done;
        e = '{data: 8'h77, lead: -1, gap: -1, tail: -1};
        send(8'h77, 1'b0, e);
        repeat (10) @(negedge clk);
        unit_en = 1'b0;
        @(negedge clk);
        chk(drv_en == 1'b0, "R10 DE after abort", int'(drv_en), 0);
        chk(txd == 1'b1, "R10 txd after abort", int'(txd), 1);
        chk(busy == 1'b0, "R10 busy after abort", int'(busy), 0);
        repeat (80) @(negedge clk);
        chk(n_done == done0, "R10 no done on abort", n_done - done0, 0);
        chk(drv_en == 1'b0, "R10 DE stays low", int'(drv_en), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule